// File: doc/BRIEF.md
# Double-Buffered Receive Message Slot

This block is the receive storage behind one message object of a CAN controller. It holds received frames of up to eight data bytes plus a four-bit length code. The receiver hands it a completed frame in one cycle. The CPU side always sees the oldest unread frame. The CPU gives a one-cycle release pulse when it has finished with that frame.

In the default double-buffered mode, two storage entries alternate. A frame that arrives while the CPU still holds the first one goes into the spare entry, and nothing is lost. If a third frame arrives before the CPU lets go of the first, it replaces the second, newer pending frame. The frame the CPU is reading is never touched. A parameter selects a single-entry mode, in which any unread frame is replaced by the next arrival.

The block reports a new-data flag and a sticky message-lost flag. Software clears the message-lost flag with a clear pulse.

Top module: `dbl_rx_slot`

## Requirements
- R1: After reset, `new_data` and `msg_lost` are both 0.
- R2: A frame written into an empty slot appears on the read side the following cycle. `rd_len` equals the written code, byte i of `rd_bytes` (bits 8i+7..8i) equals byte i of `wr_bytes` for every i below the valid count, and `new_data` is 1.
- R3: In double mode, a second frame written while one frame is unread leaves the read side unchanged, and `msg_lost` stays 0.
- R4: A release while a second frame is pending switches the read side to that frame, and `new_data` stays 1.
- R5: A release with no other frame pending clears `new_data` the next cycle.
- R6: In double mode, a frame written while two frames are unread replaces the newer one, and the read side keeps showing the older one.
- R7: Replacing an unread frame sets `msg_lost`. The flag stays 1 until a `lost_clr` pulse. A replacement in the same cycle as `lost_clr` leaves it set.
- R8: A release while `new_data` is 0 has no effect on `new_data`, `msg_lost` or later frames.
- R9: A release and a write in the same cycle are applied release first, so with two frames unread the new frame takes the freed entry and nothing is lost.
- R10: With `DOUBLE_BUF` = 0, a frame written while one is unread replaces it on the read side and sets `msg_lost`.
- R11: A length code above 8 makes all eight bytes valid. Bytes at or beyond the valid count are undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | One-cycle strobe: a completed frame is offered |
| wr_len | input | 4 | Length code of the offered frame |
| wr_bytes | input | 64 | Frame data, byte i at bits 8i+7..8i |
| rd_release | input | 1 | CPU has finished with the frame on the read side |
| lost_clr | input | 1 | Software clear of the message-lost flag |
| rd_len | output | 4 | Length code of the oldest unread frame |
| rd_bytes | output | 64 | Data of the oldest unread frame |
| new_data | output | 1 | At least one unread frame is held |
| msg_lost | output | 1 | Sticky: an unread frame was overwritten |

## Verification
The properties assume single-cycle strobes sampled on rising edges. They assume the read-side value has meaning only while `new_data` is 1, and that a release with nothing held is legal but inert. The stimulus changes inputs only at falling edges and holds reset across several edges. It mixes directed sequences that fill, overflow and drain both entries with a long stretch of random strobes. The random strobes include same-cycle release and write, releases on an empty slot, and length codes from 0 to 15.

// File: rtl/dbl_rx_slot_pkg.sv
package dbl_rx_slot_pkg;
  // number of meaningful bytes for a given length code
  function automatic int valid_count(input int code, input int max_bytes);
    return (code > max_bytes) ? max_bytes : code;
  endfunction
endpackage

// File: rtl/dbl_rx_slot_store.sv
module dbl_rx_slot_store #(
  parameter int ENTRY_W = 68,
  parameter int NBUF    = 2,
  parameter int SEL_W   = 1
) (
  input  logic               clk,
  input  logic               we,
  input  logic [SEL_W-1:0]   wsel,
  input  logic [ENTRY_W-1:0] wentry,
  input  logic [SEL_W-1:0]   rsel,
  output logic [ENTRY_W-1:0] rentry
);
  logic [ENTRY_W-1:0] mem [NBUF];

  always_ff @(posedge clk) begin
    if (we) mem[wsel] <= wentry;
  end

  assign rentry = mem[rsel];
endmodule

// File: rtl/dbl_rx_slot_ctrl.sv
module dbl_rx_slot_ctrl #(
  parameter bit DOUBLE_BUF = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_valid,
  input  logic rd_release,
  input  logic lost_clr,
  output logic we,
  output logic wsel,
  output logic rsel,
  output logic new_data,
  output logic msg_lost
);
  logic [1:0] held_q, held_a, held_n;
  logic       ptr_q, ptr_a, tgt;
  logic       rel_ok, overflow;

  always_comb begin
    held_a = held_q;
    ptr_a  = ptr_q;
    rel_ok = rd_release & held_q[ptr_q];
    if (rel_ok) begin
      held_a[ptr_q] = 1'b0;
      if (DOUBLE_BUF && held_q[~ptr_q]) ptr_a = ~ptr_q;
    end
    tgt      = (DOUBLE_BUF && held_a[ptr_a]) ? ~ptr_a : ptr_a;
    overflow = wr_valid & held_a[tgt];
    held_n   = held_a;
    if (wr_valid) held_n[tgt] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q   <= '0;
      ptr_q    <= 1'b0;
      new_data <= 1'b0;
      msg_lost <= 1'b0;
    end else begin
      held_q   <= held_n;
      ptr_q    <= ptr_a;
      new_data <= |held_n;
      msg_lost <= overflow | (msg_lost & ~lost_clr);
    end
  end

  assign we   = wr_valid;
  assign wsel = tgt;
  assign rsel = ptr_q;
endmodule

// File: rtl/dbl_rx_slot.sv
module dbl_rx_slot #(
  parameter int BYTE_W     = 8,
  parameter int MAX_BYTES  = 8,
  parameter int LEN_W      = 4,
  parameter bit DOUBLE_BUF = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_valid,
  input  logic [LEN_W-1:0]              wr_len,
  input  logic [BYTE_W*MAX_BYTES-1:0]   wr_bytes,
  input  logic                          rd_release,
  input  logic                          lost_clr,
  output logic [LEN_W-1:0]              rd_len,
  output logic [BYTE_W*MAX_BYTES-1:0]   rd_bytes,
  output logic                          new_data,
  output logic                          msg_lost
);
  localparam int DATA_W  = BYTE_W * MAX_BYTES;
  localparam int ENTRY_W = DATA_W + LEN_W;
  localparam int NBUF    = DOUBLE_BUF ? 2 : 1;

  logic we, wsel, rsel;
  logic [ENTRY_W-1:0] rentry;

  dbl_rx_slot_ctrl #(.DOUBLE_BUF(DOUBLE_BUF)) u_ctrl (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .rd_release(rd_release),
    .lost_clr(lost_clr), .we(we), .wsel(wsel), .rsel(rsel),
    .new_data(new_data), .msg_lost(msg_lost)
  );

  dbl_rx_slot_store #(.ENTRY_W(ENTRY_W), .NBUF(NBUF), .SEL_W(1)) u_store (
    .clk(clk), .we(we), .wsel(wsel), .wentry({wr_len, wr_bytes}),
    .rsel(rsel), .rentry(rentry)
  );

  assign rd_len   = rentry[ENTRY_W-1 -: LEN_W];
  assign rd_bytes = rentry[DATA_W-1:0];
endmodule

// File: rtl/dbl_rx_slot_chk.sv
module dbl_rx_slot_chk #(
  parameter int LEN_W      = 4,
  parameter int DATA_W     = 64,
  parameter bit DOUBLE_BUF = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic              rd_release,
  input logic              lost_clr,
  input logic [LEN_W-1:0]  rd_len,
  input logic [DATA_W-1:0] rd_bytes,
  input logic              new_data,
  input logic              msg_lost
);
  // R2: any accepted frame leaves data pending
  a_r2_write_sets_new: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> new_data);

  // R8: pending data only appears through a write
  a_r8_no_spurious_new: assert property (@(posedge clk) disable iff (rst)
    (!new_data && !wr_valid) |=> !new_data);

  // R7: lost flag holds until software clears it
  a_r7_lost_sticky: assert property (@(posedge clk) disable iff (rst)
    (msg_lost && !lost_clr) |=> msg_lost);

  // R7: lost flag rises only on a write
  a_r7_lost_needs_write: assert property (@(posedge clk) disable iff (rst)
    (!msg_lost && !wr_valid) |=> !msg_lost);

  generate
    if (DOUBLE_BUF) begin : g_dbl
      // R3 / R6: frame on the read side is never disturbed until released
      a_r6_read_side_stable: assert property (@(posedge clk) disable iff (rst)
        (new_data && !rd_release) |=> (new_data && $stable(rd_len) && $stable(rd_bytes)));
    end
  endgenerate
endmodule

bind dbl_rx_slot dbl_rx_slot_chk #(
  .LEN_W(LEN_W), .DATA_W(BYTE_W*MAX_BYTES), .DOUBLE_BUF(DOUBLE_BUF)
) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .rd_release(rd_release),
  .lost_clr(lost_clr), .rd_len(rd_len), .rd_bytes(rd_bytes),
  .new_data(new_data), .msg_lost(msg_lost)
);

// File: tb/dbl_rx_slot_tb.sv
module dbl_rx_slot_tb;
  import dbl_rx_slot_pkg::*;

  typedef struct packed { logic [3:0] len; logic [63:0] data; } frame_t;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, wr_valid = 0, rd_release = 0, lost_clr = 0;
  logic [3:0] wr_len = '0;
  logic [63:0] wr_bytes = '0;
  logic [3:0] d_len, s_len;
  logic [63:0] d_bytes, s_bytes;
  logic d_new, d_lost, s_new, s_lost;

  dbl_rx_slot #(.DOUBLE_BUF(1'b1)) u_dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_len(wr_len), .wr_bytes(wr_bytes),
    .rd_release(rd_release), .lost_clr(lost_clr), .rd_len(d_len), .rd_bytes(d_bytes),
    .new_data(d_new), .msg_lost(d_lost));

  dbl_rx_slot #(.DOUBLE_BUF(1'b0)) u_dut_single (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_len(wr_len), .wr_bytes(wr_bytes),
    .rd_release(rd_release), .lost_clr(lost_clr), .rd_len(s_len), .rd_bytes(s_bytes),
    .new_data(s_new), .msg_lost(s_lost));

  frame_t dq[$];
  frame_t sq[$];
  bit d_lm, s_lm;
  int vectors = 0, errors = 0;
  string cur_req = "R1";

  task automatic model_step(ref frame_t q[$], ref bit lost, input int cap,
                            input bit wv, input frame_t f, input bit rel, input bit clr);
    bit ovf = 0;
    if (rel && q.size() > 0) void'(q.pop_front());
    if (wv) begin
      if (q.size() < cap) q.push_back(f);
      else begin q[q.size()-1] = f; ovf = 1; end
    end
    if (clr) lost = 0;
    if (ovf) lost = 1;
  endtask

  task automatic cmp(input string who, ref frame_t q[$], input bit lm,
                     input logic nd, input logic ls, input logic [3:0] ln, input logic [63:0] by);
    vectors++;
    if (nd !== (q.size() > 0)) begin
      errors++; $display("FAIL %s %s new_data act=%0b exp=%0b", cur_req, who, nd, q.size() > 0);
    end
    if (ls !== lm) begin
      errors++; $display("FAIL %s %s msg_lost act=%0b exp=%0b", cur_req, who, ls, lm);
    end
    if (q.size() > 0) begin
      int n = valid_count(int'(q[0].len), 8);
      logic [63:0] m = '0;
      for (int i = 0; i < n; i++) m[8*i +: 8] = 8'hFF;
      if (ln !== q[0].len || (by & m) !== (q[0].data & m)) begin
        errors++;
        $display("FAIL %s %s frame act=%h/%h exp=%h/%h", cur_req, who, ln, by & m, q[0].len, q[0].data & m);
      end
    end
  endtask

  task automatic check_all();
    cmp("double", dq, d_lm, d_new, d_lost, d_len, d_bytes);
    cmp("single", sq, s_lm, s_new, s_lost, s_len, s_bytes);
  endtask

  task automatic apply(input bit wv, input logic [3:0] ln, input logic [63:0] by,
                       input bit rel, input bit clr);
    frame_t f;
    f.len = ln; f.data = by;
    wr_valid = wv; wr_len = ln; wr_bytes = by; rd_release = rel; lost_clr = clr;
    model_step(dq, d_lm, 2, wv, f, rel, clr);
    model_step(sq, s_lm, 1, wv, f, rel, clr);
    @(negedge clk);
    check_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    d_lm = 0; s_lm = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    cur_req = "R1"; check_all();
    cur_req = "R2"; apply(1, 4'd3, 64'h1111_2222_3333_4444, 0, 0);
    cur_req = "R3"; apply(1, 4'd8, 64'hAAAA_BBBB_CCCC_DDDD, 0, 0);   // single: R10
    cur_req = "R10"; check_all();
    cur_req = "R6"; apply(1, 4'd5, 64'h0123_4567_89AB_CDEF, 0, 0);
    cur_req = "R7"; apply(0, 0, 0, 0, 0);
    cur_req = "R4"; apply(0, 0, 0, 1, 0);
    cur_req = "R5"; apply(0, 0, 0, 1, 0);
    cur_req = "R8"; apply(0, 0, 0, 1, 0);
    cur_req = "R8"; apply(0, 0, 0, 1, 0);
    cur_req = "R7"; apply(0, 0, 0, 0, 1);
    cur_req = "R2"; apply(1, 4'd1, 64'h0000_0000_0000_005A, 0, 0);
    cur_req = "R7"; apply(1, 4'd2, 64'h0000_0000_0000_77A5, 0, 0);
    cur_req = "R7"; apply(1, 4'd7, 64'h00FE_DCBA_9876_5432, 0, 1);   // set beats clear
    cur_req = "R7"; apply(0, 0, 0, 0, 1);
    cur_req = "R9"; apply(1, 4'd6, 64'h0000_5555_6666_7777, 1, 0);
    cur_req = "R9"; apply(0, 0, 0, 1, 0);
    apply(0, 0, 0, 1, 0);
    cur_req = "R11"; apply(1, 4'd12, 64'hDEAD_BEEF_CAFE_F00D, 0, 0);
    cur_req = "R11"; apply(0, 0, 0, 1, 1);
    cur_req = "random";
    for (int k = 0; k < 3000; k++) begin
      apply(($urandom % 3) == 0, 4'($urandom), {$urandom, $urandom},
            ($urandom % 4) == 0, ($urandom % 16) == 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule